// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

This block turns one configuration-space read or write request into the short sequence of bridge register writes and the single data access that the request needs. The bridge in front of it has only two general memory windows. So the sequencer first widens window 0 until it also covers the address range of window 1. It then points window 1 at configuration space with the cycle type set to configuration. Next it forms the configuration address and performs the access. Finally it puts both windows back in their normal memory roles.

A request carries a bus number, a device/function byte, a register offset, an access size and write data. Bus 0 produces a type 0 address. On that bus the one-hot device select is split between the window offset and the window's map register, depending on the slot number. Any other bus produces a type 1 address. A write is always followed by a read-back of the same location before the windows are restored. Read data and write data are both zero-extended to the access size.

Top module: `pci_cfg_seq`

## Requirements
- R1: On bus 0 the access offset carries the function number in bits 10:8 and the register offset in bits 7:0, where bits 1:0 come from the offset. The map word uses cycle type 5 in bits 3:1, and its low-bit enable (bit 0) is 0.
- R2: On bus 0, with slot = devfn[7:3] of 12 or less, offset bit (slot + 11) is set and no device-select bit is set in the map word.
- R3: On bus 0, with a slot from 13 to 20, map-word bit (slot − 5) is set and no select bit is set in the offset. Slots above 20 set no select bit in either place.
- R4: On any other bus the offset is {bus, devfn, register offset}, and the map word is cycle type 5 with bit 0 set.
- R5: The open phase performs three writes in order. First, window 0 base gets the non-prefetchable base, size code 9 (512 MB) in bits 7:4 and enable in bit 0. Second, window 1 base gets the config base, size code 4 (16 MB) and enable. Third, map 1 gets the computed map word. The data access happens only while window 0 is 512 MB wide. Register selects are 0 = window 0 base, 1 = window 1 base, 2 = map 1.
- R6: The close phase performs three writes in order. First, window 1 base gets the prefetchable base, size code 8, prefetch bit 3 and enable. Second, map 1 gets the prefetchable PCI address bits 31:20 in bits 15:4 with cycle type 6. Third, window 0 base gets the non-prefetchable base with size code 8 and enable.
- R7: A write access is followed by a read of the same offset before the close phase. After a write, rdata_o holds the read-back value.
- R8: A request is rejected when bus, devfn or offset exceeds 255, or when the size is not 1, 2 or 4. A rejection gives done_o and err_o in the cycle after acceptance, with no register write and no access.
- R9: Read data is masked to the access size (1 → bits 7:0, 2 → bits 15:0, 4 → all). Write data presented on the access port is masked the same way.
- R10: busy_o rises in the cycle after a request is accepted and stays high until done. Requests are ignored while busy_o is high.
- R11: acc_valid_o, the offset and the direction stay stable until acc_ready_i is seen.
- R12: done_o is a single-cycle pulse, and the block is idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_write_i | input | 1 | 1 = configuration write |
| req_bus_i | input | IDX_W | Bus number |
| req_devfn_i | input | IDX_W | Device (7:3) and function (2:0) |
| req_offset_i | input | IDX_W | Register byte offset |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write data, right-justified |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Request rejected, valid with done_o |
| rdata_o | output | 32 | Zero-extended read data |
| regw_valid_o | output | 1 | Bridge register write strobe |
| regw_sel_o | output | 2 | Register select |
| regw_data_o | output | 32 | Register write value |
| acc_valid_o | output | 1 | Data access request |
| acc_write_o | output | 1 | Data access direction |
| acc_addr_o | output | 24 | Offset inside the configuration window |
| acc_size_o | output | 3 | Access size in bytes |
| acc_wdata_o | output | 32 | Masked write data |
| acc_ready_i | input | 1 | Access completes |
| acc_rdata_i | input | 32 | Access read data, right-justified |

## Verification
The bench keeps the default window bases and IDX_W = 9. The ninth index bit lets it present bus, devfn and offset values of 256, which must be rejected. It overrides the prefetchable PCI address to 0x2000_0000, so the restored map word must be 0x200C rather than a value that a fixed constant could produce by chance. Its access responder inserts a wait cycle on every access. With it, the bench drives slots 3, 12, 13, 20 and 25 on bus 0 and the largest legal type 1 indices.

// File: rtl/pci_cfg_seq_pkg.sv
package pci_cfg_seq_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CFG_AW = 24;  // 16 MB config window

  localparam logic [3:0] SZ_16M  = 4'd4;
  localparam logic [3:0] SZ_256M = 4'd8;
  localparam logic [3:0] SZ_512M = 4'd9;
  localparam logic [2:0] CYC_CFG = 3'd5;
  localparam logic [2:0] CYC_MRM = 3'd6;

  typedef enum logic [1:0] {
    SEL_WIN0 = 2'd0,
    SEL_WIN1 = 2'd1,
    SEL_MAP1 = 2'd2
  } regw_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPEN_W0, ST_OPEN_W1, ST_OPEN_M1, ST_ACCESS, ST_READBACK,
    ST_CLOSE_W1, ST_CLOSE_M1, ST_CLOSE_W0, ST_FINISH, ST_REJECT
  } seq_state_e;

  function automatic logic [WORD_W-1:0] win_word(logic [31:0] base, logic [3:0] sz, logic pf);
    return {base[31:20], 12'h000, sz, pf, 2'b00, 1'b1};
  endfunction

  function automatic logic [15:0] map_word(logic [31:0] pci_addr, logic [2:0] cyc);
    return {pci_addr[31:20], cyc, 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] size_mask(logic [2:0] sz);
    case (sz)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/pci_cfg_req_check.sv
module pci_cfg_req_check #(
  parameter int unsigned IDX_W = 9
) (
  input  logic [IDX_W-1:0] bus_i,
  input  logic [IDX_W-1:0] devfn_i,
  input  logic [IDX_W-1:0] offset_i,
  input  logic [2:0]       size_i,
  output logic             legal_o
);
  localparam int unsigned HI_W = IDX_W - 8;

  logic size_ok;
  logic idx_ok;

  generate
    if (HI_W > 0) begin : g_hi
      assign idx_ok = (bus_i[IDX_W-1:8] == '0) && (devfn_i[IDX_W-1:8] == '0) &&
                      (offset_i[IDX_W-1:8] == '0);
    end else begin : g_nohi
      assign idx_ok = 1'b1;
    end
  endgenerate

  assign size_ok = (size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4);
  assign legal_o = idx_ok && size_ok;
endmodule

// File: rtl/pci_cfg_addr_gen.sv
module pci_cfg_addr_gen
  import pci_cfg_seq_pkg::*;
(
  input  logic [7:0]        bus_i,
  input  logic [7:0]        devfn_i,
  input  logic [7:0]        offset_i,
  output logic [CFG_AW-1:0] addr_o,
  output logic [15:0]       map_o
);
  logic [4:0] slot;
  assign slot = devfn_i[7:3];

  always_comb begin
    if (bus_i == 8'd0) begin
      addr_o       = '0;
      addr_o[10:8] = devfn_i[2:0];
      addr_o[7:0]  = offset_i;
      // low slots: select bit lands inside the window offset
      for (int k = 11; k < CFG_AW; k++)
        if (32'(slot) + 32'd11 == 32'(k)) addr_o[k] = 1'b1;
      map_o = {12'h000, CYC_CFG, 1'b0};
      // high slots: select bit moves to map (map bit k = PCI addr bit k+16)
      for (int k = 8; k < 16; k++)
        if (32'(slot) == 32'(k) + 32'd5) map_o[k] = 1'b1;
    end else begin
      addr_o = {bus_i, devfn_i, offset_i};
      map_o  = {12'h000, CYC_CFG, 1'b1};
    end
  end
endmodule

// File: rtl/pci_cfg_seq_fsm.sv
module pci_cfg_seq_fsm
  import pci_cfg_seq_pkg::*;
#(
  parameter logic [31:0] NPF_BASE    = 32'h4000_0000,
  parameter logic [31:0] PF_BASE     = 32'h5000_0000,
  parameter logic [31:0] CFG_BASE    = 32'h6100_0000,
  parameter logic [31:0] PF_PCI_ADDR = 32'h1000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              reject_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [15:0]       map_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              regw_valid_o,
  output logic [1:0]        regw_sel_o,
  output logic [WORD_W-1:0] regw_data_o,
  output logic              acc_valid_o,
  output logic              acc_write_o,
  input  logic              acc_ready_i,
  input  logic [WORD_W-1:0] acc_rdata_i
);
  seq_state_e state_q, state_d;
  logic       capture;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_OPEN_W0;
                   else if (reject_i) state_d = ST_REJECT;
      ST_OPEN_W0:  state_d = ST_OPEN_W1;
      ST_OPEN_W1:  state_d = ST_OPEN_M1;
      ST_OPEN_M1:  state_d = ST_ACCESS;
      ST_ACCESS:   if (acc_ready_i) state_d = write_i ? ST_READBACK : ST_CLOSE_W1;
      ST_READBACK: if (acc_ready_i) state_d = ST_CLOSE_W1;
      ST_CLOSE_W1: state_d = ST_CLOSE_M1;
      ST_CLOSE_M1: state_d = ST_CLOSE_W0;
      ST_CLOSE_W0: state_d = ST_FINISH;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    regw_valid_o = 1'b1;
    regw_sel_o   = SEL_WIN0;
    regw_data_o  = '0;
    case (state_q)
      ST_OPEN_W0:  regw_data_o = win_word(NPF_BASE, SZ_512M, 1'b0);
      ST_OPEN_W1: begin
        regw_sel_o  = SEL_WIN1;
        regw_data_o = win_word(CFG_BASE, SZ_16M, 1'b0);
      end
      ST_OPEN_M1: begin
        regw_sel_o  = SEL_MAP1;
        regw_data_o = {16'h0000, map_i};
      end
      ST_CLOSE_W1: begin
        regw_sel_o  = SEL_WIN1;
        regw_data_o = win_word(PF_BASE, SZ_256M, 1'b1);
      end
      ST_CLOSE_M1: begin
        regw_sel_o  = SEL_MAP1;
        regw_data_o = {16'h0000, map_word(PF_PCI_ADDR, CYC_MRM)};
      end
      ST_CLOSE_W0: regw_data_o = win_word(NPF_BASE, SZ_256M, 1'b0);
      default:     regw_valid_o = 1'b0;
    endcase
  end

  assign acc_valid_o = (state_q == ST_ACCESS) || (state_q == ST_READBACK);
  assign acc_write_o = (state_q == ST_ACCESS) && write_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FINISH) || (state_q == ST_REJECT);
  assign err_o       = (state_q == ST_REJECT);

  // read data comes from the read access or the write's read-back
  assign capture = acc_valid_o && !acc_write_o && acc_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (capture) rdata_o <= acc_rdata_i & size_mask(size_i);
  end
endmodule

// File: rtl/pci_cfg_seq.sv
module pci_cfg_seq
  import pci_cfg_seq_pkg::*;
#(
  parameter int unsigned IDX_W       = 9,
  parameter logic [31:0] NPF_BASE    = 32'h4000_0000,
  parameter logic [31:0] PF_BASE     = 32'h5000_0000,
  parameter logic [31:0] CFG_BASE    = 32'h6100_0000,
  parameter logic [31:0] PF_PCI_ADDR = 32'h1000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [IDX_W-1:0]  req_bus_i,
  input  logic [IDX_W-1:0]  req_devfn_i,
  input  logic [IDX_W-1:0]  req_offset_i,
  input  logic [2:0]        req_size_i,
  input  logic [31:0]       req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       rdata_o,
  output logic              regw_valid_o,
  output logic [1:0]        regw_sel_o,
  output logic [31:0]       regw_data_o,
  output logic              acc_valid_o,
  output logic              acc_write_o,
  output logic [23:0]       acc_addr_o,
  output logic [2:0]        acc_size_o,
  output logic [31:0]       acc_wdata_o,
  input  logic              acc_ready_i,
  input  logic [31:0]       acc_rdata_i
);
  logic        accept, legal;
  logic [7:0]  bus_q, devfn_q, offset_q;
  logic        write_q;
  logic [2:0]  size_q;
  logic [31:0] wdata_q;
  logic [15:0] map_w;

  assign accept = req_valid_i && !busy_o;

  pci_cfg_req_check #(.IDX_W(IDX_W)) u_check (
    .bus_i    (req_bus_i),
    .devfn_i  (req_devfn_i),
    .offset_i (req_offset_i),
    .size_i   (req_size_i),
    .legal_o  (legal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q    <= '0;
      devfn_q  <= '0;
      offset_q <= '0;
      write_q  <= 1'b0;
      size_q   <= 3'd4;
      wdata_q  <= '0;
    end else if (accept && legal) begin
      bus_q    <= req_bus_i[7:0];
      devfn_q  <= req_devfn_i[7:0];
      offset_q <= req_offset_i[7:0];
      write_q  <= req_write_i;
      size_q   <= req_size_i;
      wdata_q  <= req_wdata_i;
    end
  end

  pci_cfg_addr_gen u_addr (
    .bus_i    (bus_q),
    .devfn_i  (devfn_q),
    .offset_i (offset_q),
    .addr_o   (acc_addr_o),
    .map_o    (map_w)
  );

  pci_cfg_seq_fsm #(
    .NPF_BASE    (NPF_BASE),
    .PF_BASE     (PF_BASE),
    .CFG_BASE    (CFG_BASE),
    .PF_PCI_ADDR (PF_PCI_ADDR)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept && legal),
    .reject_i     (accept && !legal),
    .write_i      (write_q),
    .size_i       (size_q),
    .map_i        (map_w),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .rdata_o      (rdata_o),
    .regw_valid_o (regw_valid_o),
    .regw_sel_o   (regw_sel_o),
    .regw_data_o  (regw_data_o),
    .acc_valid_o  (acc_valid_o),
    .acc_write_o  (acc_write_o),
    .acc_ready_i  (acc_ready_i),
    .acc_rdata_i  (acc_rdata_i)
  );

  assign acc_size_o  = size_q;
  assign acc_wdata_o = wdata_q & size_mask(size_q);
endmodule

// File: rtl/pci_cfg_seq_chk.sv
module pci_cfg_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic        regw_valid_o,
  input logic [1:0]  regw_sel_o,
  input logic [7:4]  regw_size_f,
  input logic        acc_valid_o,
  input logic        acc_write_o,
  input logic [23:0] acc_addr_o,
  input logic        acc_ready_i
);
  logic win0_wide;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win0_wide <= 1'b0;
    else if (regw_valid_o && regw_sel_o == 2'd0) win0_wide <= (regw_size_f == 4'd9);
  end

  AST_REGW_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regw_valid_o |-> busy_o); // R10
  AST_REJECT_AT_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && !$past(busy_o)); // R8
  AST_DONE_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o); // R12
  AST_ACC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o && !acc_ready_i |=> acc_valid_o && $stable(acc_addr_o) && $stable(acc_write_o)); // R11
  AST_MAP_FOLLOWS_WIN1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regw_valid_o && regw_sel_o == 2'd1 |=> regw_valid_o && regw_sel_o == 2'd2); // R5
  AST_ACC_WIDE_WIN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o |-> win0_wide); // R5
  AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o && acc_ready_i && acc_write_o |=> acc_valid_o && !acc_write_o && $stable(acc_addr_o)); // R7
endmodule

bind pci_cfg_seq pci_cfg_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .regw_valid_o (regw_valid_o),
  .regw_sel_o   (regw_sel_o),
  .regw_size_f  (regw_data_o[7:4]),
  .acc_valid_o  (acc_valid_o),
  .acc_write_o  (acc_write_o),
  .acc_addr_o   (acc_addr_o),
  .acc_ready_i  (acc_ready_i)
);

// File: tb/pci_cfg_seq_bench.sv
module pci_cfg_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [8:0]  req_bus_i = '0, req_devfn_i = '0, req_offset_i = '0;
  logic [2:0]  req_size_i = 3'd4;
  logic [31:0] req_wdata_i = '0;
  logic        busy_o, done_o, err_o, regw_valid_o, acc_valid_o, acc_write_o;
  logic [31:0] rdata_o, regw_data_o, acc_wdata_o;
  logic [1:0]  regw_sel_o;
  logic [23:0] acc_addr_o;
  logic [2:0]  acc_size_o;
  logic        acc_ready_i = 1'b0;
  logic [31:0] acc_rdata_i = '0;

  localparam logic [31:0] RESP = 32'hA5C3_5A3C;
  int checks = 0, fails = 0;
  int nlog = 0;
  int          lk[32];
  logic [31:0] ld[32];
  logic [31:0] last_wdata;
  logic [2:0]  last_size;

  always #10 clk_i = ~clk_i;

  pci_cfg_seq #(.IDX_W(9), .PF_PCI_ADDR(32'h2000_0000)) u_pci_cfg_seq (.*);

  // monitor and access responder (one wait cycle per access)
  always @(negedge clk_i) begin
    if (regw_valid_o && nlog < 32) begin
      lk[nlog] = int'(regw_sel_o); ld[nlog] = regw_data_o; nlog++;
    end
    if (acc_valid_o && !acc_ready_i) begin
      if (nlog < 32) begin
        lk[nlog] = acc_write_o ? 3 : 4; ld[nlog] = {8'h00, acc_addr_o}; nlog++;
      end
      last_wdata  = acc_wdata_o;
      last_size   = acc_size_o;
      acc_rdata_i = RESP;
      acc_ready_i = 1'b1;
    end else acc_ready_i = 1'b0;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(logic wr, logic [8:0] bus, logic [8:0] devfn, logic [8:0] off,
                       logic [2:0] sz, logic [31:0] wd);
    @(negedge clk_i);
    nlog = 0;
    req_write_i = wr; req_bus_i = bus; req_devfn_i = devfn; req_offset_i = off;
    req_size_i = sz; req_wdata_i = wd; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int i = 0; i < 60 && !done_o; i++) @(negedge clk_i);
  endtask

  task automatic check_seq(string tag, logic wr, logic [15:0] map, logic [23:0] addr);
    int ek[9];
    logic [31:0] ed[9];
    int n;
    ek[0] = 0; ed[0] = 32'h4000_0091;
    ek[1] = 1; ed[1] = 32'h6100_0041;
    ek[2] = 2; ed[2] = {16'h0, map};
    n = 3;
    if (wr) begin ek[n] = 3; ed[n] = {8'h0, addr}; n++; end
    ek[n] = 4; ed[n] = {8'h0, addr}; n++;
    ek[n] = 1; ed[n] = 32'h5000_0089; n++;
    ek[n] = 2; ed[n] = 32'h0000_200C; n++;
    ek[n] = 0; ed[n] = 32'h4000_0081; n++;
    chk({tag, " entries"}, 32'(nlog), 32'(n));
    for (int i = 0; i < n; i++) begin
      chk({tag, " kind"}, 32'(lk[i]), 32'(ek[i]));
      chk({tag, " data"}, ld[i], ed[i]);
    end
    chk({tag, " done"}, {31'h0, done_o}, 32'h1);
    chk({tag, " err"}, {31'h0, err_o}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R10 reset busy", {31'h0, busy_o}, 32'h0);
    chk("R12 reset done", {31'h0, done_o}, 32'h0);
    chk("R5 reset regw", {31'h0, regw_valid_o}, 32'h0);
    chk("R11 reset acc", {31'h0, acc_valid_o}, 32'h0);
  endtask

  task automatic t_type0_low();
    issue(1'b0, 9'd0, 9'h01A, 9'h010, 3'd4, 0);  // slot 3 func 2
    check_seq("R1 R2 R5 R6 slot3", 1'b0, 16'h000A, 24'h004210);
    chk("R9 full read", rdata_o, RESP);
    issue(1'b0, 9'd0, 9'h060, 9'h0FC, 3'd1, 0);  // slot 12 boundary
    check_seq("R2 slot12", 1'b0, 16'h000A, 24'h8000FC);
    chk("R9 byte read", rdata_o, 32'h0000_003C);
  endtask

  task automatic t_type0_high();
    issue(1'b0, 9'd0, 9'h06F, 9'h004, 3'd2, 0);  // slot 13 func 7
    check_seq("R3 slot13", 1'b0, 16'h010A, 24'h000704);
    chk("R9 half read", rdata_o, 32'h0000_5A3C);
    issue(1'b0, 9'd0, 9'h0A1, 9'h000, 3'd4, 0);  // slot 20 func 1
    check_seq("R3 slot20", 1'b0, 16'h800A, 24'h000100);
    issue(1'b0, 9'd0, 9'h0C8, 9'h008, 3'd4, 0);  // slot 25: no select
    check_seq("R3 slot25", 1'b0, 16'h000A, 24'h000008);
  endtask

  task automatic t_type1();
    issue(1'b0, 9'd3, 9'h02B, 9'h03C, 3'd4, 0);
    check_seq("R4 bus3", 1'b0, 16'h000B, 24'h032B3C);
  endtask

  task automatic t_write();
    issue(1'b1, 9'h0FF, 9'h0FF, 9'h0FF, 3'd1, 32'h1234_5678);
    check_seq("R7 R4 write", 1'b1, 16'h000B, 24'hFFFFFF);
    chk("R9 wdata mask", last_wdata, 32'h0000_0078);
    chk("R9 acc size", {29'h0, last_size}, 32'd1);
    chk("R7 readback data", rdata_o, 32'h0000_003C);
  endtask

  task automatic t_reject(string tag, logic [8:0] bus, logic [8:0] devfn,
                          logic [8:0] off, logic [2:0] sz);
    issue(1'b0, bus, devfn, off, sz, 0);
    chk({tag, " done"}, {31'h0, done_o}, 32'h1);
    chk({tag, " err"}, {31'h0, err_o}, 32'h1);
    chk({tag, " no writes"}, 32'(nlog), 32'd0);
    @(negedge clk_i);
    chk("R12 idle after done", {30'h0, busy_o, done_o}, 32'h0);
  endtask

  task automatic t_busy();
    @(negedge clk_i);
    nlog = 0;
    req_write_i = 1'b0; req_bus_i = 9'd0; req_devfn_i = 9'h01A; req_offset_i = 9'h010;
    req_size_i = 3'd4; req_valid_i = 1'b1;
    @(negedge clk_i);
    chk("R10 busy after accept", {31'h0, busy_o}, 32'h1);
    req_devfn_i = 9'h0A1; req_bus_i = 9'd7;  // held while busy: must be ignored
    @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int i = 0; i < 60 && !done_o; i++) @(negedge clk_i);
    check_seq("R10 ignored while busy", 1'b0, 16'h000A, 24'h004210);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_type0_low();
    t_type0_high();
    t_type1();
    t_write();
    t_reject("R8 offset256", 9'd0, 9'h008, 9'h100, 3'd4);
    t_reject("R8 bus256", 9'h100, 9'h008, 9'h000, 3'd4);
    t_reject("R8 devfn256", 9'd1, 9'h100, 9'h000, 3'd4);
    t_reject("R8 size3", 9'd0, 9'h008, 9'h000, 3'd3);
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule